// File: doc/BRIEF.md
# Independent Watchdog Timer with Key Protection

The block is a watchdog that counts on its own low-speed clock and is set up through a small 32-bit register port on the bus clock. A key register takes command words. One word opens the prescaler and reload registers for writing. Other words close them again, start the timer, or refresh the counter. Once the timer is started, nothing short of a system reset stops it. If software does not refresh the timer before its 12-bit down-counter runs out, the block drives a one-cycle reset pulse and counts again from the reload value.

Each accepted write to the prescaler or reload register is carried into the low-speed domain by a toggle handshake. A pending flag stays high in the status register until the handshake is acknowledged. New divider and reload values do not change the count in progress. They take effect the next time the counter is loaded.

Top module: `wdg_top`

## Requirements
- R1: After reset the prescaler reads 0, the reload reads 0xFFF, the key and early-warning registers read 0, status reads 0, the version register (0x3F4) reads 0x31 and the reset output is low.
- R2: While locked, writes to the prescaler (0x04) or reload (0x08) register leave their read-back values unchanged and raise no pending flag.
- R3: After the 32-bit key 0x00005555 is written to offset 0x00, writes take effect: the prescaler stores bits [3:0] and the reload stores bits [11:0].
- R4: A key of 0x00000000, or any 32-bit word other than 0x00005555, 0x0000AAAA and 0x0000CCCC, locks the registers. 0x0000AAAA and 0x0000CCCC leave the lock state as it is.
- R5: An accepted prescaler or reload write sets status bit 0 or bit 1 respectively from the next bus cycle. The flag clears by itself once the low-speed domain has taken the value. Status bits 2 and 3 always read 0.
- R6: Key 0x0000CCCC sets status bit 8 (running) in the next cycle. No later key write clears it.
- R7: While running, with reload R and prescaler code P, the reset output goes high for exactly one low-speed cycle every (R+1)*(4<<min(P,6)) low-speed cycles. The counter reloads at each expiry.
- R8: Key 0x0000AAAA while running reloads the counter, so no expiry occurs while refreshes come more often than the timeout.
- R9: New prescaler and reload values take effect only at the next counter load (start, refresh or expiry). The count already in progress keeps its old timing.
- R10: The reset output stays low while the timer has not been started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| lsclk_i | input | 1 | Low-speed counter clock |
| wr_en_i | input | 1 | Register write strobe, one bus cycle per write |
| addr_i | input | 10 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| wdg_rst_o | output | 1 | Reset pulse on expiry, low-speed domain |

## Verification
The handshake assertions assume that software never writes a configuration register again while its pending flag is still set. Under that assumption the flag is always set in the cycle after an accepted write. The bench keeps to this by polling each pending flag until it clears before the next write to that register. The low-speed clock runs slower than the bus clock and with a phase offset, so that every synchroniser sees its input held for several bus cycles. Refresh commands are spaced far enough apart that each one reaches the counter before the next is issued.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 10;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_KEY    = 10'h000;
  localparam addr_t A_PRESC  = 10'h004;
  localparam addr_t A_RELOAD = 10'h008;
  localparam addr_t A_STAT   = 10'h00C;
  localparam addr_t A_EWARN  = 10'h014;
  localparam addr_t A_VER    = 10'h3F4;

  localparam logic [31:0] K_LOCK = 32'h0000_0000;
  localparam logic [31:0] K_OPEN = 32'h0000_5555;
  localparam logic [31:0] K_KICK = 32'h0000_AAAA;
  localparam logic [31:0] K_GO   = 32'h0000_CCCC;

  localparam int S_PRE_PEND = 0;
  localparam int S_RLD_PEND = 1;
  localparam int S_RUN      = 8;

  typedef enum logic [2:0] {
    CMD_OTHER, CMD_LOCK, CMD_OPEN, CMD_KICK, CMD_GO
  } key_cmd_t;

  function automatic key_cmd_t decode_key(input logic [31:0] k);
    case (k)
      K_LOCK:  return CMD_LOCK;
      K_OPEN:  return CMD_OPEN;
      K_KICK:  return CMD_KICK;
      K_GO:    return CMD_GO;
      default: return CMD_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/wdg_sync2.sv
module wdg_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wdg_xfer.sv
// One configuration register: bus-side copy, toggle request to the slow
// domain, acknowledge back; pending while request and ack differ.
module wdg_xfer #(
  parameter int           W    = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_b_i,
  input  logic         clk_s_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_b_o,
  output logic         pend_o,
  output logic [W-1:0] q_s_o
);
  logic [W-1:0] hold_q, cap_q;
  logic         req_q, ack_q, req_s, ack_b;

  always_ff @(posedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= INIT;
      req_q  <= 1'b0;
    end else if (ld_i) begin
      hold_q <= d_i;
      req_q  <= ~req_q;
    end
  end

  wdg_sync2 #(.W(1)) u_req_sync (
    .clk_i(clk_s_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_s)
  );

  // hold_q is stable while a request is outstanding
  always_ff @(posedge clk_s_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= INIT;
      ack_q <= 1'b0;
    end else if (req_s != ack_q) begin
      cap_q <= hold_q;
      ack_q <= req_s;
    end
  end

  wdg_sync2 #(.W(1)) u_ack_sync (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_b)
  );

  assign q_b_o  = hold_q;
  assign pend_o = req_q ^ ack_b;
  assign q_s_o  = cap_q;

  p_pend_set_r5: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (ld_i && !pend_o) |=> pend_o);

  p_cap_only_on_req_r5: assert property (@(posedge clk_s_i) disable iff (!rst_ni)
    (req_s == ack_q) |=> $stable(cap_q));
endmodule

// File: rtl/wdg_keyctl.sv
module wdg_keyctl
  import wdg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_we_i,
  input  logic [31:0] key_i,
  output logic        open_o,
  output logic        run_o,
  output logic        kick_tgl_o
);
  key_cmd_t cmd;
  logic     open_q, run_q, kick_q;

  assign cmd = decode_key(key_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      run_q  <= 1'b0;
      kick_q <= 1'b0;
    end else if (key_we_i) begin
      case (cmd)
        CMD_OPEN: open_q <= 1'b1;
        CMD_KICK: if (run_q) kick_q <= ~kick_q;
        CMD_GO:   run_q  <= 1'b1;
        default:  open_q <= 1'b0;
      endcase
    end
  end

  assign open_o     = open_q;
  assign run_o      = run_q;
  assign kick_tgl_o = kick_q;

  p_run_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);

  p_run_from_go_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(key_we_i && key_i == K_GO));

  p_relock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && key_i != K_OPEN && key_i != K_KICK && key_i != K_GO) |=> !open_o);
endmodule

// File: rtl/wdg_core.sv
// Low-speed domain: prescaler, down-counter, expiry pulse.
module wdg_core #(
  parameter int CNT_W    = 12,
  parameter int PRE_W    = 4,
  parameter int MAX_CODE = 6,
  parameter int DIV_MIN  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_a_i,
  input  logic             kick_a_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic             expire_o
);
  localparam int DIV_W = $clog2(DIV_MIN) + MAX_CODE;

  logic             run_s, kick_s, run_d, kick_d;
  logic             start, kick, tick, fire, load;
  logic [PRE_W-1:0] pre_act, code_c;
  logic [DIV_W:0]   span, span_m1;
  logic [DIV_W-1:0] lim, div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire_q;

  wdg_sync2 #(.W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({run_a_i, kick_a_i}), .q_o({run_s, kick_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_d  <= 1'b0;
      kick_d <= 1'b0;
    end else begin
      run_d  <= run_s;
      kick_d <= kick_s;
    end
  end

  assign start = run_s & ~run_d;
  assign kick  = run_d & (kick_s ^ kick_d);

  assign code_c  = (pre_act > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : pre_act;
  assign span    = (DIV_W+1)'(DIV_MIN) << code_c;
  assign span_m1 = span - (DIV_W+1)'(1);
  assign lim     = span_m1[DIV_W-1:0];

  assign tick = run_d && (div_q == lim);
  assign fire = tick && (cnt_q == '0);
  assign load = start | kick | fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_act  <= '0;
      div_q    <= '0;
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= fire;
      if (load) begin
        cnt_q   <= rld_i;
        div_q   <= '0;
        pre_act <= pre_i;
      end else if (run_d) begin
        if (tick) begin
          div_q <= '0;
          cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assign expire_o = expire_q;

  p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_d |-> !expire_o);

  p_kick_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick && !start) |=> (cnt_q == $past(rld_i) && div_q == '0));

  p_hold_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !$isunknown(pre_act)) |=> $stable(pre_act));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int         CNT_W    = 12,
  parameter int         PRE_W    = 4,
  parameter int         MAX_CODE = 6,
  parameter int         DIV_MIN  = 4,
  parameter logic [7:0] REV      = 8'h31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lsclk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              wdg_rst_o
);
  logic             open, run, kick_tgl;
  logic             pre_pend, rld_pend;
  logic [PRE_W-1:0] pre_b, pre_s;
  logic [CNT_W-1:0] rld_b, rld_s;
  logic             key_we, pre_ld, rld_ld;

  assign key_we = wr_en_i && (addr_i == A_KEY);
  assign pre_ld = wr_en_i && open && (addr_i == A_PRESC);
  assign rld_ld = wr_en_i && open && (addr_i == A_RELOAD);

  wdg_keyctl u_key (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_we_i(key_we), .key_i(wdata_i),
    .open_o(open), .run_o(run), .kick_tgl_o(kick_tgl)
  );

  wdg_xfer #(.W(PRE_W), .INIT('0)) u_pre (
    .clk_b_i(clk_i), .clk_s_i(lsclk_i), .rst_ni(rst_ni),
    .ld_i(pre_ld), .d_i(wdata_i[PRE_W-1:0]),
    .q_b_o(pre_b), .pend_o(pre_pend), .q_s_o(pre_s)
  );

  wdg_xfer #(.W(CNT_W), .INIT('1)) u_rld (
    .clk_b_i(clk_i), .clk_s_i(lsclk_i), .rst_ni(rst_ni),
    .ld_i(rld_ld), .d_i(wdata_i[CNT_W-1:0]),
    .q_b_o(rld_b), .pend_o(rld_pend), .q_s_o(rld_s)
  );

  wdg_core #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .MAX_CODE(MAX_CODE), .DIV_MIN(DIV_MIN)
  ) u_core (
    .clk_i(lsclk_i), .rst_ni(rst_ni), .run_a_i(run), .kick_a_i(kick_tgl),
    .pre_i(pre_s), .rld_i(rld_s), .expire_o(wdg_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_PRESC:  rdata_o[PRE_W-1:0] = pre_b;
      A_RELOAD: rdata_o[CNT_W-1:0] = rld_b;
      A_STAT: begin
        rdata_o[S_PRE_PEND] = pre_pend;
        rdata_o[S_RLD_PEND] = rld_pend;
        rdata_o[S_RUN]      = run;
      end
      A_VER:    rdata_o[7:0] = REV;
      default:  rdata_o = '0;
    endcase
  end

  p_locked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !open && (addr_i == A_PRESC || addr_i == A_RELOAD))
      |=> ($stable(pre_b) && $stable(rld_b)));

  p_open_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && open && addr_i == A_RELOAD && !rld_pend)
      |=> (rld_b == $past(wdata_i[CNT_W-1:0])));
endmodule

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  logic        clk, lsclk, rst_n;
  logic        wr_en;
  logic [9:0]  addr;
  logic [31:0] wdata, rdata;
  logic        wdg_rst;

  int n_chk = 0, n_fail = 0;
  int scyc = 0;
  int pulses[$];
  bit prev_hi = 0;
  bit done = 0;

  // reference model of the bus-visible state
  bit        m_open = 0, m_run = 0;
  bit [3:0]  m_pre = 4'h0;
  bit [11:0] m_rld = 12'hFFF;

  wdg_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .lsclk_i(lsclk), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wdg_rst_o(wdg_rst)
  );

  initial begin clk = 0; forever #5 clk = ~clk; end
  initial begin lsclk = 0; #3; forever #20 lsclk = ~lsclk; end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    if (a == 10'h000) begin
      if (d == 32'h5555) m_open = 1;
      else if (d == 32'hCCCC) m_run = 1;
      else if (d != 32'hAAAA) m_open = 0;
    end else if (a == 10'h004 && m_open) m_pre = d[3:0];
    else if (a == 10'h008 && m_open) m_rld = d[11:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_clear(input int bitn, input string req);
    logic [31:0] d;
    rd(10'h00C, d);
    chk(d[bitn] == 1'b1, req, d[bitn], 1);
    for (int i = 0; i < 100 && d[bitn]; i++) rd(10'h00C, d);
    chk(d[bitn] == 1'b0, req, d[bitn], 0);
  endtask

  task automatic wait_pulses(input int n);
    for (int i = 0; i < 20000 && pulses.size() < n; i++) @(negedge clk);
    chk(pulses.size() >= n, "R7 pulse count", pulses.size(), n);
  endtask

  // slow-domain pulse recorder
  always @(posedge lsclk) scyc++;
  always @(negedge lsclk) begin
    if (rst_n) begin
      if (wdg_rst) begin
        pulses.push_back(scyc);
        chk(!prev_hi, "R7 pulse width", 2, 1);
      end
      prev_hi = wdg_rst;
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      if (!m_run) chk(wdg_rst == 1'b0, "R10", wdg_rst, 0);
      case (addr)
        10'h004: chk(rdata == {28'h0, m_pre}, "R2/R3 prescaler", rdata, m_pre);
        10'h008: chk(rdata == {20'h0, m_rld}, "R2/R3 reload", rdata, m_rld);
        10'h00C: chk((rdata & ~32'h3) == (m_run ? 32'h100 : 32'h0), "R5/R6 status",
                     rdata, m_run ? 32'h100 : 32'h0);
        10'h3F4: chk(rdata == 32'h31, "R1 version", rdata, 32'h31);
        default: ;
      endcase
    end
  end

  initial begin
    #1_500_000;
    chk(0, "WATCHDOG", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] d;
    int n, last, gap;
    rst_n = 0; wr_en = 0; addr = 10'h0; wdata = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(10'h000, d); chk(d == 0, "R1 key", d, 0);
    rd(10'h004, d); chk(d == 0, "R1 prescaler", d, 0);
    rd(10'h008, d); chk(d == 32'hFFF, "R1 reload", d, 32'hFFF);
    rd(10'h00C, d); chk(d == 0, "R1 status", d, 0);
    rd(10'h014, d); chk(d == 0, "R1 early-warning", d, 0);
    rd(10'h3F4, d); chk(d[7:0] == 8'h31, "R1 version", d, 32'h31);
    chk(wdg_rst == 0, "R1 reset out", wdg_rst, 0);

    // R2 locked writes ignored
    wr(10'h004, 32'h3);
    rd(10'h004, d); chk(d == 0, "R2 prescaler locked", d, 0);
    wr(10'h008, 32'h5);
    rd(10'h008, d); chk(d == 32'hFFF, "R2 reload locked", d, 32'hFFF);
    rd(10'h00C, d); chk(d[1:0] == 0, "R2 no pending", d, 0);

    // R3 unlock and write, R5 pending flags
    wr(10'h000, 32'h5555);
    wr(10'h004, 32'h0);
    wait_clear(0, "R5 prescaler pending");
    wr(10'h008, 32'h7);
    wait_clear(1, "R5 reload pending");
    rd(10'h008, d); chk(d == 7, "R3 reload written", d, 7);

    // R4 relock by zero key and by unknown key
    wr(10'h000, 32'h0);
    wr(10'h004, 32'h2);
    rd(10'h004, d); chk(d == 0, "R4 locked by zero", d, 0);
    wr(10'h000, 32'h5555);
    wr(10'h000, 32'h0001_5555);
    wr(10'h008, 32'h9);
    rd(10'h008, d); chk(d == 7, "R4 locked by other key", d, 7);
    wr(10'h000, 32'h5555);
    wr(10'h000, 32'hAAAA);
    wr(10'h008, 32'h6);
    rd(10'h008, d); chk(d == 6, "R4 refresh key keeps open", d, 6);
    wait_clear(1, "R5 reload pending");
    wr(10'h008, 32'h7);
    wait_clear(1, "R5 reload pending");

    // R10 idle, no pulses
    repeat (300) @(negedge clk);
    chk(pulses.size() == 0, "R10 no pulse before start", pulses.size(), 0);

    // R6 start, sticky running
    wr(10'h000, 32'hCCCC);
    rd(10'h00C, d); chk(d[8] == 1, "R6 running", d[8], 1);
    wr(10'h000, 32'h0);
    wr(10'h000, 32'h5555);
    wr(10'h000, 32'hBEEF);
    rd(10'h00C, d); chk(d[8] == 1, "R6 still running", d[8], 1);

    // R7 period with R=7, P=0: 32 slow cycles
    wait_pulses(3);
    chk(pulses[1] - pulses[0] == 32, "R7 period", pulses[1] - pulses[0], 32);
    chk(pulses[2] - pulses[1] == 32, "R7 period", pulses[2] - pulses[1], 32);

    // R9 new values apply at next load only
    wr(10'h000, 32'h5555);
    n = pulses.size();
    wait_pulses(n + 1);
    wr(10'h004, 32'h1);
    wait_clear(0, "R5 prescaler pending");
    wr(10'h008, 32'h2);
    wait_clear(1, "R5 reload pending");
    wait_pulses(n + 3);
    chk(pulses[n+1] - pulses[n] == 32, "R9 old timing kept",
        pulses[n+1] - pulses[n], 32);
    chk(pulses[n+2] - pulses[n+1] == 24, "R7/R9 new period",
        pulses[n+2] - pulses[n+1], 24);

    // R8 refresh postpones expiry
    n = pulses.size();
    wait_pulses(n + 1);
    n = pulses.size();
    last = 0;
    for (int k = 0; k < 6; k++) begin
      wr(10'h000, 32'hAAAA);
      last = scyc;
      repeat (40) @(negedge clk);
    end
    chk(pulses.size() == n, "R8 no expiry while refreshed", pulses.size(), n);
    wait_pulses(n + 1);
    gap = pulses[n] - last;
    chk(gap >= 24 && gap <= 30, "R8 expiry after last refresh", gap, 24);
    rd(10'h00C, d); chk(d[8] == 1, "R6 running at end", d[8], 1);

    summary();
  end
endmodule